// File: doc/BRIEF.md
# Fault-Driven Refill Way Selector

This block sits beside a set-associative translation buffer and captures what software needs to service a translation fault. When the lookup logic raises a fault, the block picks which way of the indexed set should be refilled. It then writes two register images: a select image that points at the entry (index and way), and a cause image that describes the fault (access type, virtual page, process ID).

The way for a plain miss comes from a 16-bit pseudo-random shift register with parity feedback. That register moves forward once per real fault, so replacement is spread across the ways. When a tag matched but a protection check failed, the way that matched is reported instead, so the handler rewrites the offending entry. A debug probe may walk the same lookup path without disturbing anything: a probe fault changes neither register image nor the random state.

Top module: `refill_way_sel`

## Requirements
- R1: After a synchronous reset both register images read zero and the random state holds 0xCCCC, so the first miss after reset reports way 0.
- R2: The random state steps by shifting right by one and inserting, at bit 15, the parity of the state ANDed with 0x8805; it steps exactly once per accepted fault (fault_i=1, probe_i=0) and at no other time.
- R3: For an accepted fault with hit_i=0, the reported way is the low two bits of the random state as they stood before that fault's step.
- R4: For an accepted fault with hit_i=1 (protection fault), the reported way is hit_way_i, and the random state still steps.
- R5: On an accepted fault the select image becomes zero except bits [3:0], which take vaddr_i[16:13], and bits [5:4], which take the way.
- R6: On an accepted fault the cause image takes vaddr_i[31:13] in bits [31:13] and pid_i in bits [7:0], plus a type code in bits [9:8]: request 2 (fetch) gives 0, request 0 (read) gives 1, request 1 (write) gives 2, and request 3 is treated as a read (1). Bits [12:10] keep their previous value, which is zero since reset.
- R7: A fault with probe_i=1 changes neither register image nor the random state.
- R8: Both images and the random state change together, on the clock edge that samples the fault; with fault_i=0 all three hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_i | input | 1 | Translation fault strobe, one cycle per fault |
| probe_i | input | 1 | Marks the fault as a debug probe that must leave state alone |
| hit_i | input | 1 | A tag matched (protection fault) rather than a miss |
| hit_way_i | input | 2 | Way that matched when hit_i is set |
| vaddr_i | input | 32 | Faulting virtual address |
| req_i | input | 2 | Request code: 0 read, 1 write, 2 fetch |
| pid_i | input | 8 | Current process ID |
| sel_o | output | 32 | Select register image (index, way) |
| cause_o | output | 32 | Cause register image (page, type code, process ID) |

## Verification
The way choice and the random step land in the same cycle: the way reported by a miss must use the state from before that edge, while the state moves on at that very edge. The bench sends back-to-back misses on consecutive cycles and checks each reported way against a bench model that is stepped only after the way has been taken. It also places a protection fault between misses and checks that the following miss sees a state stepped twice. A probe placed between two misses must leave the second miss's way exactly as if the probe had never happened.

// File: rtl/rws_pkg.sv
package rws_pkg;

  typedef enum logic [1:0] {
    REQ_READ  = 2'd0,
    REQ_WRITE = 2'd1,
    REQ_FETCH = 2'd2,
    REQ_RSVD  = 2'd3
  } req_e;

  // Type code written into the cause image
  function automatic logic [1:0] cause_code(input logic [1:0] req);
    logic [1:0] c;
    case (req_e'(req))
      REQ_FETCH: c = 2'd0;
      REQ_WRITE: c = 2'd2;
      default:   c = 2'd1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rws_lfsr.sv
module rws_lfsr #(
  parameter int           W    = 16,
  parameter logic [W-1:0] SEED = 16'hCCCC,
  parameter logic [W-1:0] TAPS = 16'h8805
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] masked;
  logic         fb;
  logic [W-1:0] nxt;

  always_comb begin
    masked = state_q & TAPS;
    fb     = 1'b0;
    for (int i = 0; i < W; i++) fb = fb ^ masked[i];
    nxt = {fb, state_q[W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst)        state_q <= SEED;
    else if (adv_i) state_q <= nxt;
  end

  assign state_o = state_q;

  // R2
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(state_q));

  // R2
  lfsr_shift_chk: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> state_q[W-2:0] == $past(state_q[W-1:1]));

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);

endmodule

// File: rtl/rws_way_pick.sv
module rws_way_pick #(
  parameter int WAY_W = 2
) (
  input  logic             hit_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic [WAY_W-1:0] rand_way_i,
  output logic [WAY_W-1:0] way_o
);

  always_comb begin
    way_o = hit_i ? hit_way_i : rand_way_i;
  end

endmodule

// File: rtl/rws_fault_regs.sv
module rws_fault_regs #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int IDX_W      = 4,
  parameter int WAY_W      = 2,
  parameter int PID_W      = 8,
  parameter int CODE_LSB   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       commit_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic [WAY_W-1:0]           way_i,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] vpn_i,
  input  logic [1:0]                 code_i,
  input  logic [PID_W-1:0]           pid_i,
  output logic [ADDR_W-1:0]          sel_o,
  output logic [ADDR_W-1:0]          cause_o
);

  localparam int SEL_W = IDX_W + WAY_W;

  logic [ADDR_W-1:0] sel_q;
  logic [ADDR_W-1:0] cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      cause_q <= '0;
    end else if (commit_i) begin
      sel_q                          <= '0;
      sel_q[IDX_W-1:0]               <= idx_i;
      sel_q[SEL_W-1:IDX_W]           <= way_i;
      cause_q[ADDR_W-1:PAGE_SHIFT]   <= vpn_i;
      cause_q[CODE_LSB+1:CODE_LSB]   <= code_i;
      cause_q[PID_W-1:0]             <= pid_i;
    end
  end

  assign sel_o   = sel_q;
  assign cause_o = cause_q;

  // R5
  sel_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sel_q[ADDR_W-1:SEL_W] == '0);

  // R6
  cause_gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(cause_q[PAGE_SHIFT-1:CODE_LSB+2]));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> $stable(sel_q) && $stable(cause_q));

endmodule

// File: rtl/refill_way_sel.sv
module refill_way_sel #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int IDX_W      = 4,
  parameter int WAY_W      = 2,
  parameter int PID_W      = 8,
  parameter int LFSR_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fault_i,
  input  logic              probe_i,
  input  logic              hit_i,
  input  logic [WAY_W-1:0]  hit_way_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic [1:0]        req_i,
  input  logic [PID_W-1:0]  pid_i,
  output logic [ADDR_W-1:0] sel_o,
  output logic [ADDR_W-1:0] cause_o
);

  import rws_pkg::*;

  localparam int VPN_W = ADDR_W - PAGE_SHIFT;

  logic              commit;
  logic [LFSR_W-1:0] lfsr_state;
  logic [WAY_W-1:0]  way;
  logic [IDX_W-1:0]  idx;
  logic [VPN_W-1:0]  vpn;
  logic              unused_bits;

  assign commit      = fault_i && !probe_i;
  assign idx         = vaddr_i[PAGE_SHIFT+IDX_W-1:PAGE_SHIFT];
  assign vpn         = vaddr_i[ADDR_W-1:PAGE_SHIFT];
  assign unused_bits = ^vaddr_i[PAGE_SHIFT-1:0] ^ ^lfsr_state[LFSR_W-1:WAY_W];

  rws_lfsr #(
    .W    (LFSR_W),
    .SEED (16'hCCCC),
    .TAPS (16'h8805)
  ) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .adv_i   (commit),
    .state_o (lfsr_state)
  );

  rws_way_pick #(
    .WAY_W (WAY_W)
  ) u_pick (
    .hit_i      (hit_i),
    .hit_way_i  (hit_way_i),
    .rand_way_i (lfsr_state[WAY_W-1:0]),
    .way_o      (way)
  );

  rws_fault_regs #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .IDX_W      (IDX_W),
    .WAY_W      (WAY_W),
    .PID_W      (PID_W),
    .CODE_LSB   (8)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .commit_i (commit),
    .idx_i    (idx),
    .way_i    (way),
    .vpn_i    (vpn),
    .code_i   (cause_code(req_i)),
    .pid_i    (pid_i),
    .sel_o    (sel_o),
    .cause_o  (cause_o)
  );

  // R7
  probe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fault_i && probe_i |=> $stable(sel_o) && $stable(cause_o));

  // R4
  hit_way_chk: assert property (@(posedge clk) disable iff (rst)
    fault_i && !probe_i && hit_i |=> sel_o[IDX_W+WAY_W-1:IDX_W] == $past(hit_way_i));

  // R6
  cause_pid_chk: assert property (@(posedge clk) disable iff (rst)
    fault_i && !probe_i |=> cause_o[PID_W-1:0] == $past(pid_i));

  // R5
  sel_idx_chk: assert property (@(posedge clk) disable iff (rst)
    fault_i && !probe_i |=> sel_o[IDX_W-1:0] == $past(vaddr_i[PAGE_SHIFT+IDX_W-1:PAGE_SHIFT]));

endmodule

// File: tb/tb_refill_way_sel.sv
module tb_refill_way_sel;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        fault_i, probe_i, hit_i;
  logic [1:0]  hit_way_i;
  logic [31:0] vaddr_i;
  logic [1:0]  req_i;
  logic [7:0]  pid_i;
  logic [31:0] sel_o, cause_o;

  int checks   = 0;
  int failures = 0;

  logic [15:0] m_lfsr;
  logic [31:0] m_sel, m_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  refill_way_sel dut (
    .clk(clk), .rst(rst), .fault_i(fault_i), .probe_i(probe_i), .hit_i(hit_i),
    .hit_way_i(hit_way_i), .vaddr_i(vaddr_i), .req_i(req_i), .pid_i(pid_i),
    .sel_o(sel_o), .cause_o(cause_o)
  );

  function automatic logic [15:0] step(input logic [15:0] s);
    logic p;
    logic [15:0] m;
    m = s & 16'h8805;
    p = 1'b0;
    for (int i = 0; i < 16; i++) p = p ^ m[i];
    return {p, s[15:1]};
  endfunction

  function automatic logic [1:0] code_of(input logic [1:0] r);
    if (r == 2'd2) return 2'd0;
    if (r == 2'd1) return 2'd2;
    return 2'd1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One fault cycle; updates the model; checks both images after the edge
  task automatic fault(input string req, input logic probe, input logic hit,
                       input logic [1:0] hway, input logic [31:0] va,
                       input logic [1:0] rq, input logic [7:0] pid);
    logic [1:0] w;
    @(negedge clk);
    fault_i = 1'b1; probe_i = probe; hit_i = hit; hit_way_i = hway;
    vaddr_i = va; req_i = rq; pid_i = pid;
    if (!probe) begin
      w = hit ? hway : m_lfsr[1:0];
      m_lfsr = step(m_lfsr);
      m_sel = {26'd0, w, va[16:13]};
      m_cause = {va[31:13], m_cause[12:10], code_of(rq), pid};
    end
    @(negedge clk);
    fault_i = 1'b0; probe_i = 1'b0; hit_i = 1'b0;
    chk({req, " sel"}, sel_o, m_sel);
    chk({req, " cause"}, cause_o, m_cause);
  endtask

  task automatic t_reset;
    rst = 1'b1; fault_i = 1'b0; probe_i = 1'b0; hit_i = 1'b0; hit_way_i = 2'd0;
    vaddr_i = '0; req_i = 2'd0; pid_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_lfsr = 16'hCCCC; m_sel = '0; m_cause = '0;
    chk("R1 reset sel", sel_o, 32'h0);
    chk("R1 reset cause", cause_o, 32'h0);
    // R1: first miss reports way 0
    fault("R1 first miss", 1'b0, 1'b0, 2'd3, 32'h1234_A000, 2'd0, 8'h11);
    chk("R1 first way", {30'd0, sel_o[5:4]}, 32'd0);
  endtask

  task automatic t_miss_run;
    // R2 R3: back-to-back misses track the shift register
    for (int k = 0; k < 12; k++) begin
      fault("R3 miss run", 1'b0, 1'b0, 2'd0, 32'h0000_2000 * k + 32'h8000_0000 + k,
            2'(k % 3), 8'(k * 7));
    end
  endtask

  task automatic t_probe;
    // R7: probe between two misses changes nothing
    fault("R7 before", 1'b0, 1'b0, 2'd0, 32'hDEAD_E000, 2'd1, 8'hA5);
    fault("R7 probe", 1'b1, 1'b1, 2'd2, 32'h5555_4000, 2'd2, 8'h3C);
    fault("R7 after probe miss", 1'b0, 1'b0, 2'd0, 32'h0BAD_6000, 2'd0, 8'h01);
  endtask

  task automatic t_protect;
    // R4: protection fault reports hit way and still steps
    fault("R4 prot", 1'b0, 1'b1, 2'd2, 32'hCAFE_1E00, 2'd1, 8'h77);
    fault("R4 prot way3", 1'b0, 1'b1, 2'd3, 32'h0000_0000, 2'd2, 8'hFF);
    fault("R4 miss after prot", 1'b0, 1'b0, 2'd1, 32'hFFFF_FFFF, 2'd0, 8'h80);
  endtask

  task automatic t_codes;
    // R6: each request code, R5: index field at both ends
    fault("R6 fetch", 1'b0, 1'b0, 2'd0, 32'h1000_0000, 2'd2, 8'h02);
    chk("R6 fetch code", {30'd0, cause_o[9:8]}, 32'd0);
    fault("R6 write", 1'b0, 1'b0, 2'd0, 32'h0001_E000, 2'd1, 8'h03);
    chk("R6 write code", {30'd0, cause_o[9:8]}, 32'd2);
    chk("R5 index max", {28'd0, sel_o[3:0]}, 32'd15);
    fault("R6 rsvd as read", 1'b0, 1'b0, 2'd0, 32'h7000_0000, 2'd3, 8'h04);
    chk("R6 rsvd code", {30'd0, cause_o[9:8]}, 32'd1);
    chk("R6 gap bits", {29'd0, cause_o[12:10]}, 32'd0);
  endtask

  task automatic t_idle;
    // R8: no fault, nothing moves; next miss shows state unchanged
    vaddr_i = 32'hFFFF_FFFF; pid_i = 8'hEE; hit_i = 1'b1; hit_way_i = 2'd3;
    repeat (5) @(negedge clk);
    chk("R8 idle sel", sel_o, m_sel);
    chk("R8 idle cause", cause_o, m_cause);
    fault("R8 miss after idle", 1'b0, 1'b0, 2'd0, 32'h2468_C000, 2'd0, 8'h12);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_miss_run();
    t_probe();
    t_protect();
    t_codes();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule